// File: doc/BRIEF.md
# I2C Control-Register Slave with Auto-Incrementing Subaddress

This block lets a host on a two-wire serial bus read and write a bank of 8-bit control registers. The slave answers a 7-bit device address whose top six bits are fixed at `110101`. The lowest address bit comes from the `addr_sel` pin, so two slaves can share one bus. In a write transfer the byte after the address loads an internal pointer. Every later byte is stored at the pointer, and the pointer then moves up by one. A read transfer is a write of the pointer, then a repeated start with the read address. Bytes then come back starting at that pointer, and the pointer again moves up after each byte.

SCL and SDA are sampled by the system clock through a synchroniser. A start or a stop is an SDA edge while SCL is high. A start at any point restarts addressing. A stop at any point returns the slave to idle. The slave refuses a subaddress outside the bank and drops to idle. A write beyond the top register is refused the same way. A read beyond the top keeps returning the top register. Four consecutive registers form one 32-bit value, and that value changes only when its most significant byte is written.

The protocol engine is a state machine with nine states. IDLE leaves only on a start. DEVADDR shifts in eight bits. On the eighth SCL fall it goes to DEVACK if the address matches, otherwise back to IDLE. DEVACK goes to RDBYTE for a read or to SUBADDR for a write. SUBADDR goes to SUBACK for a valid subaddress, otherwise to IDLE. SUBACK goes to WRBYTE. WRBYTE goes to WRACK while the pointer is inside the bank, otherwise to IDLE. WRACK returns to WRBYTE. RDBYTE goes to RDACK after eight bits. RDACK goes back to RDBYTE if the master acknowledged, otherwise to IDLE. A stop forces IDLE from every state, and a start forces DEVADDR from every state.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `110101` followed by `addr_sel`; bit 0 of that byte is R/W (0 write, 1 read). On a mismatch it sends no acknowledge and ignores the rest of the transfer.
- R2: Bits move most significant first. The slave acknowledges by pulling SDA low for the whole ninth clock. It leaves SDA released whenever it is not sending an acknowledge or a 0 data bit.
- R3: In a write transfer, the first byte after the address is the subaddress. It is acknowledged when it is below 16, and it sets the pointer.
- R4: A subaddress of 16 or more is not acknowledged. The slave goes idle, so no following byte of that transfer is acknowledged or stored.
- R5: Each acknowledged data byte is stored in the register at the pointer, and the pointer then increments.
- R6: A data byte written when the pointer has passed register 15 is not stored and not acknowledged. The slave then goes idle.
- R7: After a repeated start with the read address, the slave returns registers starting at the pointer set by the write phase, incrementing after each byte.
- R8: A read past register 15 keeps returning register 15.
- R9: After the master does not acknowledge a read byte, the slave releases SDA and sends no more data.
- R10: A stop in the middle of a byte returns the slave to idle, and the partial byte is not stored. A start in the middle of a byte restarts address reception, and the pointer keeps its value.
- R11: Registers 8 to 11 form `freq_o`, with register 8 as the least significant byte. `freq_o` changes only when register 11 is written, and it then takes all four bytes at once.
- R12: After reset, every register and `freq_o` are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| addr_sel | input | 1 | Selects the lowest device-address bit |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | Register contents, register i in bits 8i+7..8i |
| freq_o | output | 32 | Four-byte value, updated as one unit |

## Verification
A wrong state or bit count shows up on the next acknowledge slot. The ninth clock then reads high where a low was expected, or low where the line should be free. Either way the failure appears within one byte time. A wrong pointer or a wrong write enable changes `regs_o`, or fails to change it, a few system clocks after the eighth SCL fall. The bench therefore compares the whole register image against its own model on every clock. A premature update of `freq_o` is visible in the same cycle-by-cycle comparison, and read data gives a second, later view of the pointer.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_SUBADDR,
        ST_SUBACK,
        ST_WRBYTE,
        ST_WRACK,
        ST_RDBYTE,
        ST_RDACK
    } bus_state_e;

    localparam logic [5:0] DEV_ID_HI = 6'b110101;
endpackage

// File: rtl/i2cr_line_mon.sv
`timescale 1ns/1ps
module i2cr_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_bit
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    // Synchroniser chain; the length is chosen by SYNC_STAGES
    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_in;
                    sda_chain <= sda_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    assign sda_bit   = sda_s;
endmodule

// File: rtl/i2cr_proto_fsm.sv
`timescale 1ns/1ps
module i2cr_proto_fsm
    import i2cr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PTR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             sda_bit,
    input  logic             addr_sel,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(NUM_REGS - 1);
    localparam logic [8:0]       SUB_LIM = 9'(NUM_REGS);

    bus_state_e       state;
    bus_state_e       state_nx;
    logic [3:0]       cnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic [PTR_W-1:0] ptr;
    logic             rw;
    logic             mack;
    logic             byte_done;
    logic             addr_hit;
    logic             sub_ok;
    logic             ptr_ok;
    logic [PTR_W-1:0] ptr_rd_next;

    assign byte_done   = (cnt == 4'd8);
    assign addr_hit    = (shreg[7:1] == {DEV_ID_HI, addr_sel});
    assign sub_ok      = ({1'b0, shreg} < SUB_LIM);
    assign ptr_ok      = (ptr < PTR_END);
    assign ptr_rd_next = (ptr >= PTR_TOP) ? PTR_TOP : ptr + 1'b1;
    assign rd_addr     = (ptr >= PTR_TOP) ? PTR_TOP[IDX_W-1:0] : ptr[IDX_W-1:0];

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_DEVADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_DEVADDR: if (byte_done) state_nx = addr_hit ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  state_nx = rw ? ST_RDBYTE : ST_SUBADDR;
                ST_SUBADDR: if (byte_done) state_nx = sub_ok ? ST_SUBACK : ST_IDLE;
                ST_SUBACK:  state_nx = ST_WRBYTE;
                ST_WRBYTE:  if (byte_done) state_nx = ptr_ok ? ST_WRACK : ST_IDLE;
                ST_WRACK:   state_nx = ST_WRBYTE;
                ST_RDBYTE:  if (byte_done) state_nx = ST_RDACK;
                ST_RDACK:   state_nx = mack ? ST_RDBYTE : ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift registers, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            txsh  <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            mack  <= 1'b0;
        end else if (start_evt || stop_evt) begin
            cnt <= '0;
        end else begin
            if (scl_rise) begin
                case (state)
                    ST_DEVADDR, ST_SUBADDR, ST_WRBYTE: begin
                        shreg <= {shreg[6:0], sda_bit};
                        cnt   <= cnt + 4'd1;
                    end
                    ST_RDBYTE: cnt  <= cnt + 4'd1;
                    ST_RDACK:  mack <= ~sda_bit;
                    default: ;
                endcase
            end
            if (scl_fall) begin
                case (state)
                    ST_DEVADDR: if (byte_done) begin
                        cnt <= '0;
                        rw  <= shreg[0];
                    end
                    ST_DEVACK: begin
                        cnt <= '0;
                        if (rw) txsh <= rd_data;
                    end
                    ST_SUBADDR: if (byte_done) begin
                        cnt <= '0;
                        if (sub_ok) ptr <= shreg[PTR_W-1:0];
                    end
                    ST_WRBYTE: if (byte_done) begin
                        cnt <= '0;
                        if (ptr_ok) ptr <= ptr + 1'b1;
                    end
                    ST_RDBYTE: begin
                        if (byte_done) begin
                            cnt <= '0;
                            ptr <= ptr_rd_next;
                        end else begin
                            txsh <= {txsh[6:0], 1'b0};
                        end
                    end
                    ST_RDACK: begin
                        cnt  <= '0;
                        txsh <= rd_data;
                    end
                    ST_SUBACK, ST_WRACK: cnt <= '0;
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_addr = ptr[IDX_W-1:0];
        wr_data = shreg;
        unique case (state)
            ST_DEVACK, ST_SUBACK, ST_WRACK: sda_oe = 1'b1;
            ST_RDBYTE: sda_oe = ~txsh[7];
            ST_WRBYTE: wr_en = scl_fall & byte_done & ptr_ok;
            default: ;
        endcase
    end

    // R10: a stop leaves the slave idle with SDA released on the next cycle
    p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE) && !sda_oe);

    // R10: a start always restarts address reception
    p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_DEVADDR) && (cnt == 4'd0));

    // R2: the SDA drive only changes after an SCL fall, a start or a stop
    p_oe_on_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_evt || stop_evt));

    // R6: the pointer never runs beyond one past the top register
    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_END);
endmodule

// File: rtl/i2cr_reg_bank.sv
`timescale 1ns/1ps
module i2cr_reg_bank #(
    parameter int NUM_REGS = 16,
    parameter int GRP_BASE = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int GRP_LAST = GRP_BASE + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic [31:0]           freq_word
);
    logic [7:0] regs [NUM_REGS];
    logic       grp_commit;

    assign grp_commit = wr_en && (wr_addr == IDX_W'(GRP_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    // The group takes the new top byte together with the three stored bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_word <= '0;
        end else if (grp_commit) begin
            freq_word <= {wr_data, regs[GRP_BASE+2], regs[GRP_BASE+1], regs[GRP_BASE]};
        end
    end

    assign rd_data = regs[rd_addr];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign regs_flat[g*8 +: 8] = regs[g];
        end
    endgenerate

    // R11: the group value holds unless its last byte is being written
    p_group_atomic_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_commit |=> $stable(freq_word));
endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave #(
    parameter int NUM_REGS    = 16,
    parameter int GRP_BASE    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic                  addr_sel,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [31:0]           freq_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_evt;
    logic             stop_evt;
    logic             sda_bit;
    logic [7:0]       rd_data;
    logic [IDX_W-1:0] rd_addr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    i2cr_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_bit   (sda_bit)
    );

    i2cr_proto_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_bit   (sda_bit),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2cr_reg_bank #(.NUM_REGS(NUM_REGS), .GRP_BASE(GRP_BASE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (regs_o),
        .freq_word (freq_o)
    );
endmodule

// File: tb/i2c_regbank_slave_bench.sv
`timescale 1ns/1ps
module i2c_regbank_slave_bench;
    localparam int NREG  = 16;
    localparam int GBASE = 8;
    localparam int Q     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    logic [31:0] freq_o;
    wire sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_regbank_slave u_i2c_regbank_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .regs_o   (regs_o),
        .freq_o   (freq_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    logic [7:0] m_reg [NREG];
    logic [31:0] m_freq = '0;
    int m_ptr = 0;
    int p_addr = 0;
    logic [7:0] p_data = '0;
    logic [7:0] wq [$];
    logic [NREG*8-1:0] mvec;

    always_comb begin
        for (int i = 0; i < NREG; i++) mvec[i*8 +: 8] = m_reg[i];
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference image compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(regs_o == mvec, "R5 R6 R10 register image", regs_o, mvec);
            chk(freq_o == m_freq, "R11 group value", 128'(freq_o), 128'(m_freq));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        if (scl_m == 1'b0) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
        end else begin
            sda_m = 1'b1; tick(Q);
        end
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input bit b, output bit seen);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic model_apply();
        m_reg[p_addr] = p_data;
        if (p_addr == GBASE + 3)
            m_freq = {p_data, m_reg[GBASE+2], m_reg[GBASE+1], m_reg[GBASE]};
    endtask

    task automatic send_byte(input logic [7:0] b, input bit pend, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && pend) cmp_en = 1'b0;
            clock_bit(b[i], s);
            if (i == 0 && pend) begin
                model_apply();
                cmp_en = 1'b1;
            end
        end
        clock_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        bit s;
        for (int i = 0; i < n; i++) clock_bit(b[7-i], s);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(!give_ack, s);
    endtask

    function automatic logic [6:0] own_addr();
        return {6'b110101, addr_sel};
    endfunction

    task automatic do_write(input logic [6:0] dev, input logic [7:0] sub);
        bit ack;
        bit alive;
        bit exp;
        bus_start();
        send_byte({dev, 1'b0}, 1'b0, ack);
        alive = (dev == own_addr());
        chk(ack == alive, "R1 address acknowledge", 128'(ack), 128'(alive));
        send_byte(sub, 1'b0, ack);
        exp = alive && (sub < NREG);
        chk(ack == exp, "R3 R4 subaddress acknowledge", 128'(ack), 128'(exp));
        if (exp) m_ptr = sub;
        alive = exp;
        foreach (wq[i]) begin
            exp = alive && (m_ptr < NREG);
            if (exp) begin
                p_addr = m_ptr;
                p_data = wq[i];
                send_byte(wq[i], 1'b1, ack);
                m_ptr++;
            end else begin
                send_byte(wq[i], 1'b0, ack);
            end
            chk(ack == exp, "R5 R6 data acknowledge", 128'(ack), 128'(exp));
            alive = exp;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] sub, input int n);
        bit ack;
        logic [7:0] d;
        logic [7:0] e;
        bus_start();
        send_byte({own_addr(), 1'b0}, 1'b0, ack);
        chk(ack, "R1 address acknowledge", 128'(ack), 128'(1));
        send_byte(sub, 1'b0, ack);
        chk(ack, "R3 subaddress acknowledge", 128'(ack), 128'(1));
        m_ptr = sub;
        bus_start();
        send_byte({own_addr(), 1'b1}, 1'b0, ack);
        chk(ack, "R7 read address acknowledge", 128'(ack), 128'(1));
        for (int k = 0; k < n; k++) begin
            e = m_reg[(m_ptr >= NREG - 1) ? NREG - 1 : m_ptr];
            read_byte(k < n - 1, d);
            chk(d == e, "R2 R7 R8 read data", 128'(d), 128'(e));
            m_ptr = (m_ptr >= NREG - 1) ? NREG - 1 : m_ptr + 1;
        end
        read_byte(1'b0, d);
        chk(d == 8'hFF, "R9 released after master NACK", 128'(d), 128'hFF);
        bus_stop();
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
        tick(10);
        // R12: reset state
        chk(regs_o == '0, "R12 registers after reset", regs_o, 128'(0));
        chk(freq_o == '0, "R12 group after reset", 128'(freq_o), 128'(0));
        chk(sda_oe == 1'b0, "R12 SDA released after reset", 128'(sda_oe), 128'(0));
        rst_n = 1'b1;
        tick(5);
        cmp_en = 1'b1;

        // R5: burst write with auto-increment, then read back (R7)
        wq.delete(); wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
        do_write(own_addr(), 8'd0);
        do_read(8'd0, 3);

        // R1: wrong device address is ignored
        wq.delete(); wq.push_back(8'hEE);
        do_write(7'h6B, 8'd1);

        // R1: select pin moves the address
        addr_sel = 1'b1;
        wq.delete(); wq.push_back(8'hA5); wq.push_back(8'h5A);
        do_write(7'h6B, 8'd4);
        wq.delete(); wq.push_back(8'hFF);
        do_write(7'h6A, 8'd5);
        do_read(8'd4, 2);

        // R4: invalid subaddress
        wq.delete(); wq.push_back(8'h77); wq.push_back(8'h88);
        do_write(own_addr(), 8'h20);
        do_write(own_addr(), 8'd16);

        // R6: write past the top register
        wq.delete(); wq.push_back(8'hC3); wq.push_back(8'h3C); wq.push_back(8'h99);
        do_write(own_addr(), 8'd15);
        wq.delete(); wq.push_back(8'hE1);
        do_write(own_addr(), 8'd14);
        // R8: read past the top register
        do_read(8'd14, 4);

        // R11: partial group write leaves the value alone
        wq.delete(); wq.push_back(8'h01); wq.push_back(8'h02); wq.push_back(8'h03);
        do_write(own_addr(), 8'd8);
        chk(freq_o == 32'h0, "R11 no update before last byte", 128'(freq_o), 128'(0));
        wq.delete(); wq.push_back(8'h04);
        do_write(own_addr(), 8'd11);
        chk(freq_o == 32'h04030201, "R11 update on last byte", 128'(freq_o), 128'h04030201);
        wq.delete(); wq.push_back(8'h10); wq.push_back(8'h20); wq.push_back(8'h30); wq.push_back(8'h40);
        do_write(own_addr(), 8'd8);
        chk(freq_o == 32'h40302010, "R11 full group burst", 128'(freq_o), 128'h40302010);

        // R10: stop in the middle of a data byte
        bus_start();
        send_byte({own_addr(), 1'b0}, 1'b0, ack);
        chk(ack, "R10 address acknowledge", 128'(ack), 128'(1));
        send_byte(8'd2, 1'b0, ack);
        chk(ack, "R10 subaddress acknowledge", 128'(ack), 128'(1));
        send_bits(8'h00, 4);
        bus_stop();
        do_read(8'd2, 1);

        // R10: start in the middle of a data byte keeps the pointer
        bus_start();
        send_byte({own_addr(), 1'b0}, 1'b0, ack);
        send_byte(8'd3, 1'b0, ack);
        chk(ack, "R10 subaddress acknowledge", 128'(ack), 128'(1));
        m_ptr = 3;
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({own_addr(), 1'b1}, 1'b0, ack);
        chk(ack, "R10 read address after restart", 128'(ack), 128'(1));
        read_byte(1'b0, d);
        chk(d == m_reg[3], "R10 read after restart", 128'(d), 128'(m_reg[3]));
        bus_stop();
        tick(20);
        chk(sda_oe == 1'b0, "R2 SDA released when idle", 128'(sda_oe), 128'(0));

        cmp_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule